// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of an 8-bit accumulator datapath. Each request presents the current accumulator, one operand (taken by the surrounding datapath from a register, memory or an immediate byte) and a 4-bit operation code. The block computes the next accumulator value and, for increment and decrement, the new operand value. Both are combinational. It also holds a five-bit flag register: carry, parity, auxiliary carry, zero and sign.

The flag register loads only on a clock edge where the start strobe is high. Each operation has its own rule for which flags it writes. Compare keeps only the flags from its subtraction. The logic operations force carry low. Complement of the accumulator leaves every flag alone. Set carry and complement carry touch carry and nothing else. Add-with-carry and subtract-with-borrow take the carry currently held in the flag register.

Top module: `acc_alu`

## Requirements
- R1: Operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR, 7 compare, 8 increment operand, 9 decrement operand, 10 complement accumulator, 11 set carry, 12 complement carry. `flags_o` bits are [0] carry, [1] parity, [2] auxiliary carry, [3] zero, [4] sign. All flags are 0 after reset.
- R2: Add and add-with-carry give `acc_o` = acc + operand (+ carry flag for code 1) mod 256. The carry flag becomes the carry out of bit 7.
- R3: Subtract and subtract-with-borrow give `acc_o` = acc - operand (- carry flag for code 3) mod 256. The carry flag becomes 1 when a borrow out of bit 7 occurs.
- R4: For the arithmetic codes 0-3, 7, 8 and 9, auxiliary carry is the carry (for additions) or the borrow (for subtractions) out of bit 3.
- R5: Every code that writes result flags sets sign to result bit 7, zero to 1 when the result is 0x00, and parity to 1 when the result has an even number of 1 bits. For example, 0x44 + 0x73 gives 0xB7 with sign 1, parity 1, carry 0, zero 0 and auxiliary carry 0.
- R6: AND, OR and XOR combine acc with the operand into `acc_o` and clear carry. Auxiliary carry becomes 1 for AND and 0 for OR and XOR.
- R7: Compare leaves `acc_o` = acc and `opnd_o` = operand. It sets the flags from acc - operand: carry 1 if acc < operand, carry 0 otherwise, and zero 1 on equality.
- R8: Increment and decrement drive the operand plus or minus one (mod 256) on `opnd_o` and leave `acc_o` = acc. They update sign, zero, parity and auxiliary carry and keep carry.
- R9: Complement accumulator drives `acc_o` = ~acc and changes no flag.
- R10: Set carry forces carry to 1, and complement carry inverts it. Both keep the other four flags and pass acc through.
- R11: The flag register changes only on a clock edge with `start_i` high. Codes 13-15 pass acc and the operand through unchanged and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Commit strobe for the flag register |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Current accumulator |
| opnd_i | input | 8 | Operand byte |
| acc_o | output | 8 | Next accumulator value |
| opnd_o | output | 8 | Operand result (increment and decrement) |
| flags_o | output | 5 | Flag register contents |

## Verification
The hardest cases to reach from the ports are the ones that depend on a carry flag left behind by an earlier operation. These are add-with-carry and subtract-with-borrow with the incoming carry set, and complement carry, especially where that carry sits right at the nibble or byte boundary (0xFF + 0x00 + 1, 0x00 - 0x00 - 1). Directed sequences first set carry with set carry and then issue those codes on the boundary operands. A long random run then leaves the carry state to drift through chains of committed and uncommitted operations. A bench model tracks the flag register across the whole sequence, so a wrong carry source shows up at a later operation.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned NFLAGS = 5;

  localparam logic [OP_W-1:0] OP_ADD = 4'd0;
  localparam logic [OP_W-1:0] OP_ADC = 4'd1;
  localparam logic [OP_W-1:0] OP_SUB = 4'd2;
  localparam logic [OP_W-1:0] OP_SBB = 4'd3;
  localparam logic [OP_W-1:0] OP_AND = 4'd4;
  localparam logic [OP_W-1:0] OP_OR  = 4'd5;
  localparam logic [OP_W-1:0] OP_XOR = 4'd6;
  localparam logic [OP_W-1:0] OP_CMP = 4'd7;
  localparam logic [OP_W-1:0] OP_INC = 4'd8;
  localparam logic [OP_W-1:0] OP_DEC = 4'd9;
  localparam logic [OP_W-1:0] OP_CMA = 4'd10;
  localparam logic [OP_W-1:0] OP_STC = 4'd11;
  localparam logic [OP_W-1:0] OP_CMC = 4'd12;

  localparam int unsigned FL_CY = 0;
  localparam int unsigned FL_P  = 1;
  localparam int unsigned FL_AC = 2;
  localparam int unsigned FL_Z  = 3;
  localparam int unsigned FL_S  = 4;

  typedef enum logic [1:0] {LG_AND = 2'd0, LG_OR = 2'd1, LG_XOR = 2'd2} logic_sel_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W   = 8,
  parameter int unsigned NIB = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,   // carry for add, borrow for sub
  output logic [W-1:0] res_o,
  output logic         cout_o,  // carry for add, borrow for sub
  output logic         aux_o
);
  localparam int unsigned LW = NIB + 1;
  localparam int unsigned HW = W - NIB + 1;

  logic [W-1:0]  b_eff;
  logic          c0;
  logic [LW-1:0] lo;
  logic [HW-1:0] hi;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    c0     = sub_i ? ~cin_i : cin_i;
    lo     = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + LW'(c0);
    hi     = {1'b0, a_i[W-1:NIB]} + {1'b0, b_eff[W-1:NIB]} + HW'(lo[NIB]);
    res_o  = {hi[HW-2:0], lo[NIB-1:0]};
    cout_o = hi[HW-1] ^ sub_i;
    aux_o  = lo[NIB] ^ sub_i;
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      default: res_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
  parameter int unsigned NF = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NF-1:0] d_i,
  output logic [NF-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end

  // R1: register empty while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) p_reset_clear_r1: assert (q_o == '0);
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [OP_W-1:0]     op_i,
  input  logic [W-1:0]        acc_i,
  input  logic [W-1:0]        opnd_i,
  output logic [W-1:0]        acc_o,
  output logic [W-1:0]        opnd_o,
  output logic [NFLAGS-1:0]   flags_o
);
  localparam int unsigned NIB = W / 2;

  logic [NFLAGS-1:0] flags_q, flags_d;
  logic              cy_q;
  logic              ar_sub, ar_cin, ar_cout, ar_aux;
  logic [W-1:0]      ar_res, id_res, lg_res;
  logic              id_cout, id_aux;
  logic_sel_e        lg_sel;
  logic [W-1:0]      res_sel;
  logic              wr_szp;

  assign cy_q   = flags_q[FL_CY];
  assign ar_sub = (op_i == OP_SUB) || (op_i == OP_SBB) || (op_i == OP_CMP);
  assign ar_cin = ((op_i == OP_ADC) || (op_i == OP_SBB)) ? cy_q : 1'b0;

  alu_addsub #(.W(W), .NIB(NIB)) u_acc_arith (
    .a_i(acc_i), .b_i(opnd_i), .sub_i(ar_sub), .cin_i(ar_cin),
    .res_o(ar_res), .cout_o(ar_cout), .aux_o(ar_aux)
  );

  // operand +/- 1 shares the adder structure with a zero addend
  alu_addsub #(.W(W), .NIB(NIB)) u_opnd_step (
    .a_i(opnd_i), .b_i('0), .sub_i(op_i == OP_DEC), .cin_i(1'b1),
    .res_o(id_res), .cout_o(id_cout), .aux_o(id_aux)
  );

  always_comb begin
    unique case (op_i)
      OP_AND:  lg_sel = LG_AND;
      OP_OR:   lg_sel = LG_OR;
      default: lg_sel = LG_XOR;
    endcase
  end

  alu_logic #(.W(W)) u_logic (
    .a_i(acc_i), .b_i(opnd_i), .sel_i(lg_sel), .res_o(lg_res)
  );

  always_comb begin
    acc_o   = acc_i;
    opnd_o  = opnd_i;
    flags_d = flags_q;
    res_sel = ar_res;
    wr_szp  = 1'b0;
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        acc_o          = ar_res;
        wr_szp         = 1'b1;
        flags_d[FL_CY] = ar_cout;
        flags_d[FL_AC] = ar_aux;
      end
      OP_CMP: begin
        wr_szp         = 1'b1;
        flags_d[FL_CY] = ar_cout;
        flags_d[FL_AC] = ar_aux;
      end
      OP_AND, OP_OR, OP_XOR: begin
        acc_o          = lg_res;
        res_sel        = lg_res;
        wr_szp         = 1'b1;
        flags_d[FL_CY] = 1'b0;
        flags_d[FL_AC] = (op_i == OP_AND);
      end
      OP_INC, OP_DEC: begin
        opnd_o         = id_res;
        res_sel        = id_res;
        wr_szp         = 1'b1;
        flags_d[FL_AC] = id_aux;
      end
      OP_CMA: acc_o = ~acc_i;
      OP_STC: flags_d[FL_CY] = 1'b1;
      OP_CMC: flags_d[FL_CY] = ~cy_q;
      default: ;
    endcase
    if (wr_szp) begin
      flags_d[FL_S] = res_sel[W-1];
      flags_d[FL_Z] = (res_sel == '0);
      flags_d[FL_P] = ~^res_sel;
    end
  end

  alu_flag_reg #(.NF(NFLAGS)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(start_i), .d_i(flags_d), .q_o(flags_q)
  );

  assign flags_o = flags_q;

  p_hold_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(flags_o));
  p_cma_no_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == OP_CMA) |=> $stable(flags_o));
  p_logic_clr_cy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)) |=> !flags_o[FL_CY]);
  p_stc_only_cy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == OP_STC) |=> flags_o[FL_CY] && $stable(flags_o[NFLAGS-1:1]));
  p_cmc_flip_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == OP_CMC) |=> flags_o[FL_CY] != $past(flags_o[FL_CY]));
  p_step_keeps_cy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (op_i == OP_INC || op_i == OP_DEC)) |=> $stable(flags_o[FL_CY]));
  p_cmp_eq_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == OP_CMP && acc_i == opnd_i) |=> flags_o[FL_Z] && !flags_o[FL_CY]);
endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic [7:0] acc_o, opnd_o;
  logic [4:0] flags_o;

  int n_chk = 0, n_fail = 0;
  logic [4:0] mflags = '0;
  bit done = 0;

  acc_alu dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic string req_of(logic [3:0] op);
    case (op)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4, 5, 6: return "R6";
      7:       return "R7";
      8, 9:    return "R8";
      10:      return "R9";
      11, 12:  return "R10";
      default: return "R11";
    endcase
  endfunction

  // returns {acc, opnd, flags}; flags = {S,Z,AC,P,CY}
  function automatic logic [20:0] model(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic [4:0] f);
    int r, c, n;
    logic [7:0] ra = a, rb = b, v = 8'h00;
    logic [4:0] nf = f;
    bit szp = 0;
    case (op)
      0, 1: begin
        c = (op == 1) ? int'(f[0]) : 0;
        r = int'(a) + int'(b) + c;
        n = int'(a[3:0]) + int'(b[3:0]) + c;
        v = r[7:0]; ra = v; szp = 1;
        nf[0] = r > 255; nf[2] = n > 15;
      end
      2, 3, 7: begin
        c = (op == 3) ? int'(f[0]) : 0;
        r = int'(a) - int'(b) - c;
        n = int'(a[3:0]) - int'(b[3:0]) - c;
        v = r[7:0]; szp = 1;
        if (op != 7) ra = v;
        nf[0] = r < 0; nf[2] = n < 0;
      end
      4, 5, 6: begin
        v = (op == 4) ? (a & b) : (op == 5) ? (a | b) : (a ^ b);
        ra = v; szp = 1; nf[0] = 0; nf[2] = (op == 4);
      end
      8: begin v = b + 8'd1; rb = v; szp = 1; nf[2] = (b[3:0] == 4'hF); end
      9: begin v = b - 8'd1; rb = v; szp = 1; nf[2] = (b[3:0] == 4'h0); end
      10: ra = ~a;
      11: nf[0] = 1;
      12: nf[0] = ~f[0];
      default: ;
    endcase
    if (szp) begin
      n = 0;
      for (int i = 0; i < 8; i++) n += int'(v[i]);
      nf[4] = v[7]; nf[3] = (v == 0); nf[1] = (n % 2 == 0);
    end
    return {ra, rb, nf};
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] op, logic [7:0] a, logic [7:0] b, bit st);
    logic [20:0] e;
    @(negedge clk_i);
    op_i = op; acc_i = a; opnd_i = b; start_i = st;
    e = model(op, a, b, mflags);
    #1;
    check(req_of(op), "acc", acc_o, e[20:13]);
    check(req_of(op), "opnd", opnd_o, e[12:5]);
    @(negedge clk_i);
    start_i = 0;
    if (st) mflags = e[4:0];
    // flag encodings per R1, values per R4 and R5
    check(st ? {req_of(op), "/R4/R5"} : "R11 idle", "flags", {3'b0, flags_o}, {3'b0, mflags});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    #(CLK_PERIOD * 2);
    check("R1", "reset flags", {3'b0, flags_o}, 8'h00);
    @(negedge clk_i) rst_ni = 1;
    @(negedge clk_i);
    check("R1", "post-reset flags", {3'b0, flags_o}, 8'h00);

    apply(4'd0, 8'h44, 8'h73, 1);               // R5 worked example
    check("R5", "example flags", {3'b0, flags_o}, 8'h12);
    apply(4'd7, 8'h15, 8'hC2, 1);               // R7 less
    apply(4'd7, 8'hC2, 8'h15, 1);               // R7 greater
    apply(4'd7, 8'h5A, 8'h5A, 1);               // R7 equal
    apply(4'd11, 8'h00, 8'h00, 1);              // R10 set carry
    apply(4'd1, 8'hFF, 8'h00, 1);               // R2 carry-in wraps, R4 nibble carry
    apply(4'd11, 8'h00, 8'h00, 1);
    apply(4'd3, 8'h00, 8'h00, 1);               // R3 borrow-in underflow
    apply(4'd12, 8'h10, 8'h20, 1);              // R10 complement carry
    apply(4'd8, 8'h33, 8'hFF, 1);               // R8 increment wraps
    apply(4'd9, 8'h33, 8'h00, 1);               // R8 decrement wraps
    apply(4'd4, 8'hF0, 8'h0F, 1);               // R6 AND zero result
    apply(4'd10, 8'hA5, 8'h00, 1);              // R9
    apply(4'd13, 8'h12, 8'h34, 1);              // R11 reserved
    apply(4'd15, 8'h56, 8'h78, 1);
    apply(4'd0, 8'hFF, 8'h01, 0);               // R11 no strobe

    for (int k = 0; k < 3000; k++)
      apply(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), $urandom_range(0, 7) != 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule